// File: doc/BRIEF.md
# UART DMA Request Level Generator

This block drives the two active-low handshake levels that an external DMA controller watches beside a UART: one requests a read of received characters, the other requests more characters to transmit. It does not store data. It watches the receive and transmit occupancy counts, a trigger-reached flag and a character time-out flag from the receive path, and two configuration bits: a buffering enable and a transfer-style select. From these it decides whether each request line is asserted.

Two transfer styles exist. The single-transfer style suits a controller that moves one character per grant. The receive request follows "any character present", and the transmit request follows "transmit path empty". The multi-transfer style suits burst movers. The receive request waits for the trigger level or a time-out and then holds until the receive path is drained. The transmit request stays open until the transmit buffer is completely full. With buffering disabled (plain character mode) the block always uses the single-transfer style, whatever the select bit says.

Each side is a small state machine. Receive states: `RXS_IDLE` (nothing buffered), `RXS_PEND` (characters buffered below trigger, multi style only) and `RXS_REQ` (request asserted). Receive transitions:
- IDLE to REQ when data arrives in single style, or when data arrives with trigger or time-out in multi style.
- IDLE to PEND when data arrives without trigger or time-out in multi style.
- PEND to REQ on trigger, on time-out, or on a switch to single style.
- PEND to IDLE and REQ to IDLE when the count returns to zero.

Transmit states follow the occupancy: `TXS_EMPTY`, `TXS_PARTIAL` and `TXS_FULL`. The request is asserted only in EMPTY under single style, and in every state except FULL under multi style. Both outputs are registered and settle on the clock edge that samples the inputs.

Top module: `dma_ready_gen`

## Requirements
- R1: While reset is high and on the first edge after it, `rx_dma_req_n` is 1 (inactive) and `tx_dma_req_n` is 0 (active).
- R2: The multi-transfer style is in force only when `fifo_en`=1 and `multi_sel`=1. With `fifo_en`=0 the block behaves as single style even with `multi_sel`=1.
- R3: In single style, `rx_dma_req_n` goes to 0 on the first clock edge at which `rx_level` is nonzero.
- R4: In single style, `rx_dma_req_n` returns to 1 on the first edge at which `rx_level` is zero.
- R5: In single style, `rx_trig_hit` and `rx_timeout` have no effect on `rx_dma_req_n`.
- R6: In multi style, with `rx_dma_req_n`=1 and neither `rx_trig_hit` nor `rx_timeout` set, `rx_dma_req_n` stays 1 at the next edge even when `rx_level` is nonzero.
- R7: In multi style, `rx_level` nonzero together with `rx_trig_hit`=1 drives `rx_dma_req_n` to 0 at the next edge.
- R8: In multi style, `rx_level` nonzero together with `rx_timeout`=1 drives `rx_dma_req_n` to 0 at the next edge.
- R9: In multi style, once `rx_dma_req_n` is 0 it stays 0 while `rx_level` is nonzero, even after the trigger and time-out flags drop. It returns to 1 on the edge at which `rx_level` is zero.
- R10: In single style, `tx_dma_req_n` is 0 at the edge after `tx_level`=0 and 1 at the edge after `tx_level` is nonzero.
- R11: In multi style, `tx_dma_req_n` is 1 at the edge after `tx_level` reaches DEPTH (16 by default).
- R12: In multi style, `tx_dma_req_n` is 0 at the edge after `tx_level` is below DEPTH, including right after leaving full.
- R13: A style change takes effect on the next edge. A receive side held pending in multi style with characters buffered asserts its request once single style is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| fifo_en | input | 1 | Buffering enable from the control register |
| multi_sel | input | 1 | Transfer-style select, 1 = multi-transfer |
| rx_level | input | CNT_W | Characters held in the receive path |
| rx_trig_hit | input | 1 | Receive trigger level reached |
| rx_timeout | input | 1 | Receive character time-out pending |
| tx_level | input | CNT_W | Characters held in the transmit path |
| rx_dma_req_n | output | 1 | Receive DMA request, active low |
| tx_dma_req_n | output | 1 | Transmit DMA request, active low |

## Verification
A receive state machine stuck in PEND or IDLE shows up at the receive request on the very next edge after a trigger, a time-out, or a change to single style. The request line stays high when it should have dropped. A machine that leaves REQ too early shows up one edge after the trigger flag drops while characters remain. The transmit side has no memory beyond its occupancy class, so a wrong full threshold or a wrong style decode becomes visible within one cycle of the count reaching DEPTH or DEPTH-1. Every scenario therefore compares both outputs at each edge, so that any divergence is caught in the cycle it first appears.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;

    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_MULTI  = 1'b1
    } xfer_mode_e;

    typedef enum logic [1:0] {
        RXS_IDLE = 2'd0,
        RXS_PEND = 2'd1,
        RXS_REQ  = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TXS_EMPTY   = 2'd0,
        TXS_PARTIAL = 2'd1,
        TXS_FULL    = 2'd2
    } tx_state_e;

endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
    import dma_rdy_pkg::*;
(
    input  logic       fifo_en,
    input  logic       multi_sel,
    output xfer_mode_e mode
);

    // Burst style needs buffering; character mode falls back to single.
    always_comb begin
        if (fifo_en && multi_sel) mode = XFER_MULTI;
        else                      mode = XFER_SINGLE;
    end

endmodule

// File: rtl/dma_rx_fsm.sv
module dma_rx_fsm
    import dma_rdy_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_mode_e       mode,
    input  logic [CNT_W-1:0] rx_level,
    input  logic             trig_hit,
    input  logic             char_tmo,
    output logic             rx_req_n
);

    rx_state_e state_q, state_d;
    logic      has_data;
    logic      burst_go;

    assign has_data = (rx_level != '0);
    assign burst_go = trig_hit || char_tmo;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXS_IDLE: begin
                if (has_data) begin
                    if (mode == XFER_SINGLE || burst_go) state_d = RXS_REQ;
                    else                                 state_d = RXS_PEND;
                end
            end
            RXS_PEND: begin
                if (!has_data)                            state_d = RXS_IDLE;
                else if (mode == XFER_SINGLE || burst_go) state_d = RXS_REQ;
            end
            RXS_REQ: begin
                if (!has_data) state_d = RXS_IDLE;
            end
            default: state_d = RXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RXS_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) rx_req_n <= 1'b1;
        else     rx_req_n <= (state_d != RXS_REQ);
    end

    p_single_assert_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_SINGLE && has_data) |=> !rx_req_n);

    p_drain_release_r4: assert property (@(posedge clk) disable iff (rst)
        !has_data |=> rx_req_n);

    p_multi_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_MULTI && rx_req_n && !trig_hit && !char_tmo) |=> rx_req_n);

    p_multi_go_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_MULTI && has_data && trig_hit) |=> !rx_req_n);

    p_multi_tmo_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_MULTI && has_data && char_tmo) |=> !rx_req_n);

    p_multi_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!rx_req_n && has_data) |=> !rx_req_n);

endmodule

// File: rtl/dma_tx_fsm.sv
module dma_tx_fsm
    import dma_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_mode_e       mode,
    input  logic [CNT_W-1:0] tx_level,
    output logic             tx_req_n
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    tx_state_e state_q, state_d;

    always_comb begin
        if (tx_level == '0)           state_d = TXS_EMPTY;
        else if (tx_level >= FULL_LVL) state_d = TXS_FULL;
        else                          state_d = TXS_PARTIAL;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TXS_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_req_n <= 1'b0;
        end else begin
            unique case (mode)
                XFER_SINGLE: tx_req_n <= (state_d != TXS_EMPTY);
                XFER_MULTI:  tx_req_n <= (state_d == TXS_FULL);
                default:     tx_req_n <= 1'b1;
            endcase
        end
    end

    p_single_tx_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_SINGLE) |=> (tx_req_n == (state_q != TXS_EMPTY)));

    p_full_close_r11: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_MULTI && tx_level == FULL_LVL) |=> tx_req_n);

    p_room_open_r12: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_MULTI && tx_level < FULL_LVL) |=> !tx_req_n);

endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen
    import dma_rdy_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             multi_sel,
    input  logic [CNT_W-1:0] rx_level,
    input  logic             rx_trig_hit,
    input  logic             rx_timeout,
    input  logic [CNT_W-1:0] tx_level,
    output logic             rx_dma_req_n,
    output logic             tx_dma_req_n
);

    xfer_mode_e mode;

    dma_mode_decode u_mode (
        .fifo_en   (fifo_en),
        .multi_sel (multi_sel),
        .mode      (mode)
    );

    dma_rx_fsm #(.CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .rx_level (rx_level),
        .trig_hit (rx_trig_hit),
        .char_tmo (rx_timeout),
        .rx_req_n (rx_dma_req_n)
    );

    dma_tx_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .tx_level (tx_level),
        .tx_req_n (tx_dma_req_n)
    );

    p_reset_levels_r1: assert property (@(posedge clk)
        rst |=> (rx_dma_req_n && !tx_dma_req_n));

    p_char_mode_single_r2: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && tx_level != '0) |=> tx_dma_req_n);

endmodule

// File: tb/dma_ready_gen_tb.sv
module dma_ready_gen_tb_top;

    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fifo_en = 1'b0;
    logic             multi_sel = 1'b0;
    logic [CNT_W-1:0] rx_level = '0;
    logic             rx_trig_hit = 1'b0;
    logic             rx_timeout = 1'b0;
    logic [CNT_W-1:0] tx_level = '0;
    logic             rx_dma_req_n;
    logic             tx_dma_req_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic  exp_rx_q[$];
    logic  exp_tx_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    dma_ready_gen #(.DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .fifo_en      (fifo_en),
        .multi_sel    (multi_sel),
        .rx_level     (rx_level),
        .rx_trig_hit  (rx_trig_hit),
        .rx_timeout   (rx_timeout),
        .tx_level     (tx_level),
        .rx_dma_req_n (rx_dma_req_n),
        .tx_dma_req_n (tx_dma_req_n)
    );

    task automatic compare(input logic act_rx, input logic act_tx,
                           input logic e_rx, input logic e_tx, input string tag);
        checks++;
        if (act_rx !== e_rx || act_tx !== e_tx) begin
            errors++;
            $display("FAIL %s: rx_n=%b tx_n=%b expected rx_n=%b tx_n=%b",
                     tag, act_rx, act_tx, e_rx, e_tx);
        end
    endtask

    // Driver: drive one cycle of stimulus at the falling edge and queue the
    // levels expected after the following rising edge.
    task automatic step(input logic fen, input logic sel, input int rxc,
                        input logic trig, input logic tmo, input int txc,
                        input logic e_rx, input logic e_tx, input string tag);
        @(negedge clk);
        fifo_en     = fen;
        multi_sel   = sel;
        rx_level    = CNT_W'(rxc);
        rx_trig_hit = trig;
        rx_timeout  = tmo;
        tx_level    = CNT_W'(txc);
        exp_rx_q.push_back(e_rx);
        exp_tx_q.push_back(e_tx);
        tag_q.push_back(tag);
    endtask

    // Monitor: five ns after each rising edge, compare against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_rx_q.size() > 0) begin
                compare(rx_dma_req_n, tx_dma_req_n,
                        exp_rx_q.pop_front(), exp_tx_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        for (int i = 0; i < 2000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        compare(rx_dma_req_n, tx_dma_req_n, 1'b1, 1'b0, "R1 reset levels");
        @(negedge clk);
        rst = 1'b0;

        // Single style (fifo_en=1, multi_sel=0)
        step(1, 0, 0, 0, 0, 0, 1, 0, "R4 empty receive idle");
        step(1, 0, 1, 0, 0, 0, 0, 0, "R3 first character asserts");
        step(1, 0, 3, 0, 0, 0, 0, 0, "R3 more characters hold");
        step(1, 0, 0, 0, 0, 0, 1, 0, "R4 drained releases");
        step(1, 0, 0, 1, 1, 0, 1, 0, "R5 flags ignored when empty");
        step(1, 0, 2, 0, 0, 0, 0, 0, "R5 asserts without flags");
        step(1, 0, 0, 1, 1, 0, 1, 0, "R5 flags do not hold request");
        step(1, 0, 0, 0, 0, 1, 1, 1, "R10 one tx char closes");
        step(1, 0, 0, 0, 0, 0, 1, 0, "R10 tx empty reopens");

        // Character mode: select bit set but buffering off
        step(0, 1, 1, 0, 0, 1, 0, 1, "R2 character mode is single");
        step(0, 1, 0, 0, 0, 0, 1, 0, "R2 character mode drain");

        // Multi style
        step(1, 1, 0, 0, 0, 0, 1, 0, "R6 multi empty");
        step(1, 1, 2, 0, 0, 1, 1, 0, "R6 below trigger waits");
        step(1, 1, 4, 1, 0, 1, 0, 0, "R7 trigger asserts");
        step(1, 1, 3, 0, 0, 1, 0, 0, "R9 holds after trigger drops");
        step(1, 1, 1, 0, 0, 1, 0, 0, "R9 holds with one left");
        step(1, 1, 0, 0, 0, 1, 1, 0, "R9 releases when drained");
        step(1, 1, 1, 0, 0, 1, 1, 0, "R6 single char waits");
        step(1, 1, 1, 0, 1, 1, 0, 0, "R8 time-out asserts");
        step(1, 1, 1, 0, 0, 1, 0, 0, "R9 holds after time-out");
        step(1, 1, 0, 0, 0, 1, 1, 0, "R9 time-out drain");
        step(1, 1, 0, 1, 0, 1, 1, 0, "R7 trigger with no data no effect");
        step(1, 1, 0, 0, 0, 15, 1, 0, "R12 one slot left open");
        step(1, 1, 0, 0, 0, 16, 1, 1, "R11 full closes");
        step(1, 1, 0, 0, 0, 16, 1, 1, "R11 stays closed while full");
        step(1, 1, 0, 0, 0, 15, 1, 0, "R12 reopens at free slot");

        // Style change
        step(1, 1, 2, 0, 0, 0, 1, 0, "R13 pending in multi");
        step(1, 0, 2, 0, 0, 0, 0, 0, "R13 switch to single asserts");
        step(1, 1, 2, 0, 0, 8, 0, 0, "R13 back to multi keeps request");
        step(1, 0, 2, 0, 0, 8, 0, 1, "R13 single tx closes on next edge");
        step(1, 0, 0, 0, 0, 0, 1, 0, "R4 final drain");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule